// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status word of a 16-bit accumulator-style processor. Eleven live bits sit inside a 16-bit word: the condition flags that the ALU reports (carry, zero, overflow, negative), the mode bits (decimal arithmetic, index width, data width), an interrupt-disable bit and a 3-bit interrupt priority level. The five upper bits always read as zero.

Each cycle the next flag values are built in layers, so a fixed winner exists whenever commands coincide:

1. Per-flag ALU updates are applied first.
2. Single-flag set and clear commands for carry and interrupt-disable follow.
3. Mask-wide set and clear over the low eight bits come next.
4. An interrupt-accept event forces interrupt-disable on.
5. A full-word restore (used when returning from an interrupt) overrides everything.

A small gate combines pending interrupt requests with the interrupt-disable bit. Requests of the maskable class are held off by that bit. Watchdog, software-break and divide-by-zero requests pass regardless.

Top module: `psr_status_reg`

## Requirements
- R1: `status_word` places carry at bit 0, zero at bit 1, interrupt-disable at bit 2, decimal at bit 3, index-length at bit 4, data-length at bit 5, overflow at bit 6, negative at bit 7 and the priority level at bits 10..8. Bits 15..11 always read 0.
- R2: After a synchronous active-low reset, `status_word` is 16'h0004. Interrupt-disable is set; all other flags, the length selects and the priority level are 0.
- R3: For each k, when `alu_en[k]` is 1 the flag selected by k (0 carry, 1 zero, 2 overflow, 3 negative) takes `alu_val[k]` on the next edge. Flags whose enable is 0 keep their value.
- R4: `set_carry`/`clr_carry` and `set_intdis`/`clr_intdis` set or clear their flag. They override an ALU update of the same flag, and a clear wins over a set in the same cycle.
- R5: `mask_set` ORs `mask_bits` into bits 7..0.
- R6: `mask_clr` clears in bits 7..0 every bit that is 1 in `mask_bits`. It is applied after `mask_set`, ALU updates and single-flag commands, so it wins over all three.
- R7: `irq_accept` leaves interrupt-disable at 1 on the next edge, even when a clear of that bit arrives in the same cycle.
- R8: `ipl_load` writes `ipl_new` into bits 10..8. Otherwise the level is kept.
- R9: `restore_we` loads `restore_word[10:0]` into bits 10..0 and ignores bits 15..11. It wins over every other command in the same cycle.
- R10: `irq_take` is 1 exactly when `irq_req_bypass` is 1, or when `irq_req_maskable` is 1 while interrupt-disable is 0.
- R11: With no command active, `status_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_en | input | 4 | Per-flag ALU update enables {N,V,Z,C} |
| alu_val | input | 4 | ALU flag results {N,V,Z,C} |
| set_carry | input | 1 | Set carry |
| clr_carry | input | 1 | Clear carry |
| set_intdis | input | 1 | Set interrupt-disable |
| clr_intdis | input | 1 | Clear interrupt-disable |
| mask_set | input | 1 | OR mask into bits 7..0 |
| mask_clr | input | 1 | Clear masked bits in 7..0 |
| mask_bits | input | 8 | Mask operand |
| irq_accept | input | 1 | Interrupt accepted this cycle |
| ipl_load | input | 1 | Load priority level |
| ipl_new | input | 3 | New priority level |
| restore_we | input | 1 | Full-word restore strobe |
| restore_word | input | 16 | Word to restore |
| irq_req_maskable | input | 1 | Pending maskable interrupt request |
| irq_req_bypass | input | 1 | Pending request that ignores interrupt-disable |
| status_word | output | 16 | Current status word |
| irq_take | output | 1 | Interrupt may be taken |

## Verification
The hardest cases to reach are commands that collide in one cycle: an ALU update, a single-flag command and both mask commands acting on the same bit, or an interrupt accept landing together with a clear of interrupt-disable.

The bench first uses the restore path to plant a pseudo-random base word. It then fires one collision pattern against that base, so every mask value and every combination of ALU enables and single-flag commands is applied on top of known, varied contents. Restore words carry garbage in the upper bits to show that those bits are dropped.

// File: rtl/psr_pkg.sv
// Package: shared widths and bit positions of the status word.
// Assumes a 16-bit word with 11 live bits; positions are fixed by the datapath
// that decodes them.
package psr_pkg;
    localparam int WORD_W = 16;
    localparam int FLAG_W = 8;
    localparam int IPL_W  = 3;
    localparam int LIVE_W = FLAG_W + IPL_W;
    localparam int ALU_N  = 4;

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_I = 2;
    localparam int POS_D = 3;
    localparam int POS_X = 4;
    localparam int POS_M = 5;
    localparam int POS_V = 6;
    localparam int POS_N = 7;

    // Map an ALU flag lane (0 C, 1 Z, 2 V, 3 N) to its word position.
    function automatic int alu_pos(input int lane);
        case (lane)
            0:       alu_pos = POS_C;
            1:       alu_pos = POS_Z;
            2:       alu_pos = POS_V;
            default: alu_pos = POS_N;
        endcase
    endfunction
endpackage

// File: rtl/psr_alu_merge.sv
// Module: applies per-flag ALU results, then single-flag set/clear commands.
// Assumes clear is layered after set so a clear wins on collision.
module psr_alu_merge
    import psr_pkg::*;
#(
    parameter int FW = FLAG_W,
    parameter int AN = ALU_N
) (
    input  logic [FW-1:0] flags_in,
    input  logic [AN-1:0] alu_en,
    input  logic [AN-1:0] alu_val,
    input  logic          set_carry,
    input  logic          clr_carry,
    input  logic          set_intdis,
    input  logic          clr_intdis,
    output logic [FW-1:0] flags_out
);
    logic [FW-1:0] alu_applied;

    // Per-lane ALU override of the selected flag.
    always_comb begin
        alu_applied = flags_in;
        for (int k = 0; k < AN; k++) begin
            if (alu_en[k]) alu_applied[alu_pos(k)] = alu_val[k];
        end
    end

    // Explicit carry and interrupt-disable commands over the ALU result.
    always_comb begin
        flags_out = alu_applied;
        if (set_carry)  flags_out[POS_C] = 1'b1;
        if (clr_carry)  flags_out[POS_C] = 1'b0;
        if (set_intdis) flags_out[POS_I] = 1'b1;
        if (clr_intdis) flags_out[POS_I] = 1'b0;
    end
endmodule

// File: rtl/psr_mask_unit.sv
// Module: mask-wide set, then mask-wide clear, then interrupt-accept masking.
// Assumes the caller feeds it the result of the ALU/single-command layer.
module psr_mask_unit
    import psr_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  logic [FW-1:0] flags_in,
    input  logic          mask_set,
    input  logic          mask_clr,
    input  logic [FW-1:0] mask_bits,
    input  logic          irq_accept,
    output logic [FW-1:0] flags_out
);
    logic [FW-1:0] or_stage;
    logic [FW-1:0] and_stage;

    // Set layer: OR mask into the flags.
    assign or_stage  = mask_set ? (flags_in | mask_bits) : flags_in;
    // Clear layer: remove masked bits, after the set layer.
    assign and_stage = mask_clr ? (or_stage & ~mask_bits) : or_stage;

    // Interrupt acceptance forces the disable flag on last.
    always_comb begin
        flags_out = and_stage;
        if (irq_accept) flags_out[POS_I] = 1'b1;
    end
endmodule

// File: rtl/psr_ipl_unit.sv
// Module: holds the interrupt priority level.
// Assumes restore has priority over a level load; resets to level 0.
module psr_ipl_unit
    import psr_pkg::*;
#(
    parameter int LW = IPL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ipl_load,
    input  logic [LW-1:0] ipl_new,
    input  logic          restore_we,
    input  logic [LW-1:0] restore_ipl,
    output logic [LW-1:0] ipl_q
);
    // Level register: restore, else load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          ipl_q <= '0;
        else if (restore_we) ipl_q <= restore_ipl;
        else if (ipl_load)   ipl_q <= ipl_new;
    end
endmodule

// File: rtl/psr_irq_gate.sv
// Module: combines pending requests with the interrupt-disable flag.
// Assumes bypass-class requests (watchdog, break, divide fault) are pre-merged.
module psr_irq_gate (
    input  logic intdis,
    input  logic req_maskable,
    input  logic req_bypass,
    output logic take
);
    // Maskable requests wait on the disable flag; bypass requests do not.
    assign take = req_bypass | (req_maskable & ~intdis);
endmodule

// File: rtl/psr_status_reg.sv
// Module: processor status word, top level.
// Assumes one command set per cycle with fixed layered priority:
// ALU < single commands < mask set < mask clear < irq accept < restore.
module psr_status_reg
    import psr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ALU_N-1:0]     alu_en,
    input  logic [ALU_N-1:0]     alu_val,
    input  logic                 set_carry,
    input  logic                 clr_carry,
    input  logic                 set_intdis,
    input  logic                 clr_intdis,
    input  logic                 mask_set,
    input  logic                 mask_clr,
    input  logic [FLAG_W-1:0]    mask_bits,
    input  logic                 irq_accept,
    input  logic                 ipl_load,
    input  logic [IPL_W-1:0]     ipl_new,
    input  logic                 restore_we,
    input  logic [WORD_W-1:0]    restore_word,
    input  logic                 irq_req_maskable,
    input  logic                 irq_req_bypass,
    output logic [WORD_W-1:0]    status_word,
    output logic                 irq_take
);
    localparam logic [FLAG_W-1:0] FLAG_RST = FLAG_W'(1) << POS_I;
    localparam int                PAD_W    = WORD_W - LIVE_W;

    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] after_alu;
    logic [FLAG_W-1:0] after_mask;
    logic [IPL_W-1:0]  ipl_q;
    logic              unused_restore_hi;

    // Upper restore bits carry no state.
    assign unused_restore_hi = ^restore_word[WORD_W-1:LIVE_W];

    psr_alu_merge #(.FW(FLAG_W), .AN(ALU_N)) i_alu_merge (
        .flags_in   (flags_q),
        .alu_en     (alu_en),
        .alu_val    (alu_val),
        .set_carry  (set_carry),
        .clr_carry  (clr_carry),
        .set_intdis (set_intdis),
        .clr_intdis (clr_intdis),
        .flags_out  (after_alu)
    );

    psr_mask_unit #(.FW(FLAG_W)) i_mask_unit (
        .flags_in   (after_alu),
        .mask_set   (mask_set),
        .mask_clr   (mask_clr),
        .mask_bits  (mask_bits),
        .irq_accept (irq_accept),
        .flags_out  (after_mask)
    );

    psr_ipl_unit #(.LW(IPL_W)) i_ipl_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .ipl_load    (ipl_load),
        .ipl_new     (ipl_new),
        .restore_we  (restore_we),
        .restore_ipl (restore_word[LIVE_W-1:FLAG_W]),
        .ipl_q       (ipl_q)
    );

    // Flag register: restore overrides the layered next value.
    always_ff @(posedge clk) begin
        if (!rst_n)          flags_q <= FLAG_RST;
        else if (restore_we) flags_q <= restore_word[FLAG_W-1:0];
        else                 flags_q <= after_mask;
    end

    // Word assembly with constant-zero padding above the live bits.
    assign status_word = {{PAD_W{1'b0}}, ipl_q, flags_q};

    psr_irq_gate i_irq_gate (
        .intdis       (flags_q[POS_I]),
        .req_maskable (irq_req_maskable),
        .req_bypass   (irq_req_bypass),
        .take         (irq_take)
    );
endmodule

// File: rtl/psr_status_reg_chk.sv
// Checker: temporal properties of the status word, bound to the top module.
module psr_status_reg_chk
    import psr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ALU_N-1:0]     alu_en,
    input logic [ALU_N-1:0]     alu_val,
    input logic                 set_carry,
    input logic                 clr_carry,
    input logic                 set_intdis,
    input logic                 clr_intdis,
    input logic                 mask_set,
    input logic                 mask_clr,
    input logic [FLAG_W-1:0]    mask_bits,
    input logic                 irq_accept,
    input logic                 ipl_load,
    input logic [IPL_W-1:0]     ipl_new,
    input logic                 restore_we,
    input logic [WORD_W-1:0]    restore_word,
    input logic                 irq_req_maskable,
    input logic                 irq_req_bypass,
    input logic [WORD_W-1:0]    status_word,
    input logic                 irq_take
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[WORD_W-1:LIVE_W] == '0);

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !mask_clr && !restore_we) |=>
        ((status_word[FLAG_W-1:0] & $past(mask_bits)) == $past(mask_bits)));

    p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && !irq_accept && !restore_we) |=>
        ((status_word[FLAG_W-1:0] & $past(mask_bits)) == '0));

    p_irq_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !restore_we) |=> status_word[POS_I]);

    p_ipl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_load && !restore_we) |=> (status_word[LIVE_W-1:FLAG_W] == $past(ipl_new)));

    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restore_we |=> (status_word[LIVE_W-1:0] == $past(restore_word[LIVE_W-1:0])));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_we && !mask_set && !mask_clr && alu_en == '0 && !set_carry &&
         !clr_carry && !set_intdis && !clr_intdis && !irq_accept && !ipl_load)
        |=> $stable(status_word));
endmodule

bind psr_status_reg psr_status_reg_chk i_chk (.*);

// File: tb/test_psr_status_reg.sv
module test_psr_status_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  alu_en, alu_val;
    logic        set_carry, clr_carry, set_intdis, clr_intdis;
    logic        mask_set, mask_clr;
    logic [7:0]  mask_bits;
    logic        irq_accept, ipl_load;
    logic [2:0]  ipl_new;
    logic        restore_we;
    logic [15:0] restore_word;
    logic        irq_req_maskable, irq_req_bypass;
    logic [15:0] status_word;
    logic        irq_take;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] expw;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_status_reg i_psr_status_reg (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_en = '0; alu_val = '0;
        set_carry = 0; clr_carry = 0; set_intdis = 0; clr_intdis = 0;
        mask_set = 0; mask_clr = 0; mask_bits = '0;
        irq_accept = 0; ipl_load = 0; ipl_new = '0;
        restore_we = 0; restore_word = '0;
        irq_req_maskable = 0; irq_req_bypass = 0;
    endtask

    // Next word from the requirements' layered priority.
    function automatic logic [15:0] model(input logic [15:0] cur);
        logic [7:0] f;
        logic [2:0] lvl;
        int pos [4] = '{0, 1, 6, 7};
        if (restore_we) return {5'b0, restore_word[10:0]};
        f = cur[7:0];
        lvl = cur[10:8];
        for (int k = 0; k < 4; k++) if (alu_en[k]) f[pos[k]] = alu_val[k];
        if (set_carry)  f[0] = 1'b1;
        if (clr_carry)  f[0] = 1'b0;
        if (set_intdis) f[2] = 1'b1;
        if (clr_intdis) f[2] = 1'b0;
        if (mask_set)   f = f | mask_bits;
        if (mask_clr)   f = f & ~mask_bits;
        if (irq_accept) f[2] = 1'b1;
        if (ipl_load)   lvl = ipl_new;
        return {5'b0, lvl, f};
    endfunction

    // Inputs already driven at a negedge: clock once, check at next negedge.
    task automatic step(input string req);
        expw = model(expw);
        @(negedge clk);
        check(req, status_word, expw);
        idle();
    endtask

    task automatic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Plant a base word through the restore path, upper bits garbage.
    task automatic plant(input logic [15:0] w);
        restore_we = 1; restore_word = w;
        step("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expw = 16'h0004;
        check("R2", status_word, 16'h0004);

        // R11: idle cycles keep the word
        step("R11");
        step("R11");

        // R5/R6: every mask, set, clear, and both together on random bases
        for (int m = 0; m < 256; m++) begin
            next_rand(); plant(lfsr);
            mask_set = 1; mask_bits = 8'(m); step("R5");
            next_rand(); plant(lfsr);
            mask_clr = 1; mask_bits = 8'(m); step("R6");
            next_rand(); plant(lfsr);
            mask_set = 1; mask_clr = 1; mask_bits = 8'(m);
            alu_en = lfsr[3:0]; alu_val = lfsr[7:4]; step("R6");
        end

        // R3/R4: all ALU enable/value patterns, then with single commands
        for (int e = 0; e < 16; e++) begin
            for (int v = 0; v < 16; v++) begin
                next_rand(); plant(lfsr);
                alu_en = 4'(e); alu_val = 4'(v); step("R3");
            end
        end
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 4; e++) begin
                next_rand(); plant(lfsr);
                {set_carry, clr_carry, set_intdis, clr_intdis} = 4'(c);
                alu_en = {e[1], 2'b00, e[0]}; alu_val = lfsr[11:8];
                step("R4");
            end
        end

        // R7: accept beats clears of interrupt-disable
        for (int c = 0; c < 4; c++) begin
            plant(16'hF800);
            irq_accept = 1; clr_intdis = c[0]; mask_clr = c[1]; mask_bits = 8'h04;
            step("R7");
            check("R7", {15'b0, status_word[2]}, 16'h0001);
        end

        // R8: all priority levels
        for (int l = 0; l < 8; l++) begin
            ipl_load = 1; ipl_new = 3'(l); step("R8");
            check("R8", {13'b0, status_word[10:8]}, 16'(l));
        end

        // R9: restore beats a concurrent everything
        next_rand();
        restore_we = 1; restore_word = 16'hFFFF ^ lfsr;
        mask_set = 1; mask_bits = 8'hFF; irq_accept = 1; ipl_load = 1; ipl_new = 3'd5;
        alu_en = 4'hF; alu_val = 4'hF;
        step("R9");
        plant(16'hFFFF);
        check("R1", status_word, 16'h07FF);
        plant(16'h0000);
        check("R1", status_word, 16'h0000);

        // R10: gating of requests by interrupt-disable, exhaustive
        for (int i = 0; i < 2; i++) begin
            plant(i[0] ? 16'h0004 : 16'h0000);
            for (int r = 0; r < 4; r++) begin
                irq_req_maskable = r[0]; irq_req_bypass = r[1];
                #1;
                check("R10", {15'b0, irq_take}, {15'b0, r[1] | (r[0] & ~i[0])});
                step("R11");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule